// File: doc/BRIEF.md
# Gated Synchronous Clock Divider

The block divides one input clock by successive powers of two. A single down-counting register chain, clocked by one internal gated clock, drives every output. The outputs therefore share their rising edges exactly: whenever a slower output rises, every faster output rises in the same input cycle. With the default configuration the outputs run at one half, one quarter and one eighth of the input frequency.

A common enable stops and restarts the divider. The enable is registered on the falling edge of the input clock, and the internal clock is the input clock ANDed with that register. The internal clock can therefore only be opened or closed while it is already low, and no shortened high pulse can reach the divider stages. While the block is stopped, every output keeps its value. When the block is started again, counting continues from the held count. An active-low asynchronous reset clears every stage to a known phase, so several instances that share clock, enable and reset stay aligned.

Top module: `clk_div_gated`

## Requirements
- R1: With the enable held high, output bit k of `div_o` toggles every 2^k rising input edges. Each of its high and low phases lasts exactly 2^k input periods, giving a frequency of f_clk / 2^(k+1).
- R2: `div_o` is the value of a down counter. On every rising edge where bit k rises, all bits below k rise on the same edge, and instances of different width that share clock, enable and reset agree on their common low bits.
- R3: `en_i` is captured only on the falling edge of `clk_i`. A change of `en_i` takes effect at the first rising edge that follows the next falling edge, whether the change is made in the high or the low phase.
- R4: When the captured enable is low, `div_o` does not change on rising edges of `clk_i`.
- R5: When the captured enable returns high, counting resumes from the held value. The next step is exactly one decrement, with no skipped or extra edge.
- R6: While `rst_ni` is low, `div_o` is all zeros, and this takes effect at once without a clock edge. The captured enable is also cleared.
- R7: After `rst_ni` is released with `en_i` high, the first counted rising edge (the rising edge after the first falling edge following release) moves `div_o` from all zeros to all ones, so all outputs rise together.
- R8: The internal gated clock is never high while `clk_i` is low, and it only switches between enabled and disabled while `clk_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| en_i | input | 1 | Common enable, captured on the falling edge of clk_i |
| div_o | output | STAGES | Bit k carries f_clk / 2^(k+1) |

## Verification
The bench builds the block with its default of three stages and compares it against a second instance of five stages. With three stages, the counter wraps within a short vector walk, so the all-ones rise and the return through zero are both observed. The five-stage instance exposes the 16-period phase of its slowest bit. It also confirms that instances of different width agree on their shared bits while enable changes at random times in both clock phases.

// File: rtl/cdg_pkg.sv
package cdg_pkg;
  localparam int unsigned CDG_STAGES_DEF = 3;
  localparam int unsigned CDG_STAGES_MAX = 16;
endpackage

// File: rtl/cdg_enable_reg.sv
module cdg_enable_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o
);
  // captured on the falling edge so the gate only moves while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_i;
  end
endmodule

// File: rtl/cdg_gate.sv
module cdg_gate (
  input  logic clk_i,
  input  logic en_q_i,
  output logic gclk_o
);
  assign gclk_o = clk_i & en_q_i;
endmodule

// File: rtl/cdg_counter.sv
module cdg_counter #(
  parameter int unsigned STAGES = 3
) (
  input  logic              gclk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] cnt_o
);
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic borrow;
    logic q_r;
    if (k == 0) begin : g_lsb
      assign borrow = 1'b1;
    end else begin : g_upper
      assign borrow = ~|cnt_o[k-1:0];
    end
    always_ff @(posedge gclk_i or negedge rst_ni) begin
      if (!rst_ni)     q_r <= 1'b0;
      else if (borrow) q_r <= ~q_r;
    end
    assign cnt_o[k] = q_r;
  end
endmodule

// File: rtl/clk_div_gated.sv
module clk_div_gated #(
  parameter int unsigned STAGES = cdg_pkg::CDG_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [STAGES-1:0] div_o
);
  if (STAGES < 1 || STAGES > cdg_pkg::CDG_STAGES_MAX) begin : g_bad_cfg
    initial $error("clk_div_gated: STAGES out of range");
  end

  logic en_q;
  logic gclk;

  cdg_enable_reg i_enable_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .en_q_o (en_q)
  );

  cdg_gate i_gate (
    .clk_i  (clk_i),
    .en_q_i (en_q),
    .gclk_o (gclk)
  );

  cdg_counter #(.STAGES(STAGES)) i_counter (
    .gclk_i (gclk),
    .rst_ni (rst_ni),
    .cnt_o  (div_o)
  );
endmodule

// File: rtl/cdg_checker.sv
module cdg_checker #(
  parameter int unsigned STAGES = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              gclk_i,
  input logic [STAGES-1:0] div_o
);
  logic en_s;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_s <= 1'b0;
    else         en_s <= en_i;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i)
    !rst_ni |-> div_o == '0); // R6

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> $stable(div_o)); // R4

  AST_STEP_WHEN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s |=> div_o[0] != $past(div_o[0])); // R5

  AST_GCLK_LOW_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gclk_i == 1'b0); // R8

  for (genvar k = 1; k < STAGES; k++) begin : g_align
    AST_SHARED_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_o[k]) |-> $rose(div_o[k-1])); // R2
  end
endmodule

bind clk_div_gated cdg_checker #(.STAGES(STAGES)) i_cdg_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .gclk_i (gclk),
  .div_o  (div_o)
);

// File: tb/test_clk_div_gated.sv
`timescale 1ns/1ps
module test_clk_div_gated;
  localparam int unsigned W = 3;
  localparam int unsigned WW = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic en_i = 1'b0;
  logic [W-1:0]  div_o;
  logic [WW-1:0] div_w;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  clk_div_gated #(.STAGES(W)) i_clk_div_gated (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_o(div_o));

  clk_div_gated #(.STAGES(WW)) i_clk_div_gated_w5 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .div_o(div_w));

  // requirement model: enable captured on falling edge, down count on rising edge
  logic         ref_en;
  logic [W-1:0] ref_cnt;
  always @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_en <= 1'b0; else ref_en <= en_i;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ref_cnt <= '0; else if (ref_en) ref_cnt <= ref_cnt - 1'b1;

  // {en for next step, expected div_o}
  localparam logic [3:0] VEC [13] = '{
    4'b1_000, 4'b1_111, 4'b1_110, 4'b0_101, 4'b0_101, 4'b1_101, 4'b1_100,
    4'b1_011, 4'b0_010, 4'b1_010, 4'b1_001, 4'b1_000, 4'b1_111};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] held;
    int run [WW];
    bit seen [WW];
    logic [WW-1:0] prev;

    // R6: reset with clock running and enable high
    #1 rst_ni = 1'b0;
    en_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 chk("R6 reset holds zero", div_o, 0);
    en_i = 1'b0;
    @(posedge clk_i); #1 rst_ni = 1'b1;

    // vector walk (R1 R2 R4 R5 count sequence)
    for (int i = 0; i < 13; i++) begin
      @(posedge clk_i); #1;
      chk("R4/R5 vector", div_o, VEC[i][2:0]);
      chk("R2 wide instance agrees", div_w[W-1:0], VEC[i][2:0]);
      en_i = VEC[i][3];
    end

    // R3: enable raised in low phase waits for the next falling edge
    en_i = 1'b0;
    @(posedge clk_i); @(posedge clk_i);
    held = div_o;
    @(negedge clk_i); #1 en_i = 1'b1;
    @(posedge clk_i); #1 chk("R3 low-phase change not yet active", div_o, held);
    @(posedge clk_i); #1 chk("R3 active after next falling edge", div_o, held - 1'b1);
    // R3: enable dropped in high phase
    en_i = 1'b0;
    held = div_o;
    @(posedge clk_i); #1 chk("R3 high-phase drop", div_o, held);
    @(posedge clk_i); #1 chk("R4 hold while off", div_o, held);
    en_i = 1'b1;
    @(posedge clk_i); #1 chk("R5 resume one step", div_o, held - 1'b1);

    // R1: phase widths on the wide instance
    for (int k = 0; k < WW; k++) begin run[k] = 0; seen[k] = 1'b0; end
    @(negedge clk_i); prev = div_w;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk_i);
      for (int k = 0; k < WW; k++) begin
        run[k]++;
        if (div_w[k] != prev[k]) begin
          if (seen[k]) chk($sformatf("R1 width bit%0d", k), run[k], 1 << k);
          seen[k] = 1'b1;
          run[k] = 0;
        end
      end
      prev = div_w;
    end

    // R6: asynchronous reset in the low phase
    @(negedge clk_i); #0.5 rst_ni = 1'b0;
    #0.5 chk("R6 async clear", div_o, 0);
    chk("R6 async clear wide", div_w, 0);

    // R7: release with enable high
    en_i = 1'b1;
    @(posedge clk_i); #1 rst_ni = 1'b1;
    @(posedge clk_i); #1 chk("R7 all rise together", div_o, {W{1'b1}});
    chk("R7 wide all rise", div_w, {WW{1'b1}});

    // R3/R4/R5 random enable toggles in both phases vs model
    for (int c = 0; c < 400; c++) begin
      @(negedge clk_i);
      chk("R4/R5 random vs model", div_o, ref_cnt);
      chk("R2 random alignment", div_w[W-1:0], div_o);
      #1; if ($urandom_range(0, 3) == 0) en_i = ~en_i;
      #2; if ($urandom_range(0, 3) == 0) en_i = ~en_i;
    end

    finish_run();
  end
endmodule